// File: doc/BRIEF.md
# Pin Function Crossbar

This block routes 24 physical IO pins to the signals of internal function blocks: a quadrature-style position decoder with true and inverted A, B and N inputs, and a serial interface with clock, data-in, data-out and chip-select. Every pin has a selection byte. The byte chooses what the pin does. It can drive a fixed low or high level, float, drive one of the function outputs, or feed its sampled level to one of the function inputs. Pins 0 to 15 form the first IO group and pins 16 to 23 the second. All 24 are handled the same way and are numbered one after the other.

Software loads the selection bytes through a small synchronous register port. The byte for pin *n* sits at address *n*. One function output may drive any number of pins at once, for example to add drive strength. When several pins feed the same function input, the input is the OR of their levels. From reset until a pin's byte is written, the pin floats. The routing itself is combinational, so a signal that passes through the crossbar gains no clock latency.

Top module: `pin_xbar`

## Requirements
- R1: During reset and in the first cycle after it, every selection byte reads 0x00. Every pin_oe and pin_o bit is 0, and cfg_rdata is 0x00.
- R2: A write with cfg_we=1 to an address below 24 stores cfg_wdata for that pin. cfg_rdata shows the stored byte of cfg_addr one clock after the address is presented. If the same edge also writes that address, cfg_rdata shows the value from before the write.
- R3: Code 0x01 sets pin_oe=1 and pin_o=0. Code 0x02 sets pin_oe=1 and pin_o=1. Code 0x03 sets pin_oe=0.
- R4: Code 0x00 and every code from 0x0E to 0xFF set pin_oe=0 and pin_o=0, and the pin adds nothing to any function input.
- R5: Code 0x0A drives func_out[0] (serial clock), 0x0C drives func_out[1] (serial data out) and 0x0D drives func_out[2] (chip select) onto pin_o with pin_oe=1. Any number of pins may select the same output, and all of them carry it together.
- R6: Codes 0x04 to 0x09 route pin_i to func_in[0] to func_in[5], in the order A, A inverted, B, B inverted, N, N inverted. Code 0x0B routes pin_i to func_in[6] (serial data in). Such a pin has pin_oe=0.
- R7: Each func_in bit is the OR of pin_i over all pins that select it, and it is 0 when no pin selects it.
- R8: A new selection byte acts on pin_oe, pin_o and func_in right after the write edge. The paths pin_i to func_in and func_out to pin_o are combinational.
- R9: Writes to addresses 24 and above are ignored, and reads from them return 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_addr | input | 5 | Selection byte address (pin number) |
| cfg_we | input | 1 | Write enable |
| cfg_wdata | input | 8 | Byte to write |
| cfg_rdata | output | 8 | Registered read-back byte |
| func_out | input | 3 | Function outputs: serial clock, data out, chip select |
| func_in | output | 7 | Function inputs: A, An, B, Bn, N, Nn, serial data in |
| pin_i | input | 24 | Sampled pin levels |
| pin_o | output | 24 | Pin output values |
| pin_oe | output | 24 | Pin output enables |

## Verification
A stored selection byte that is wrong, or a decoder that maps a code wrongly, shows up on that pin's pin_oe or pin_o in the first cycle after the write edge. It also shows up as a missing or extra func_in bit as soon as pin_i is driven. A corrupted store appears on cfg_rdata one clock after the address is presented. A lost OR term or an output that reaches only some of its pins shows up only with the multi-pin patterns. For that reason the bench maps the same function to two or three pins and toggles each pin on its own.

// File: rtl/pin_xbar_pkg.sv
package pin_xbar_pkg;

  localparam int SEL_W    = 8;
  localparam int NUM_FIN  = 7;
  localparam int NUM_FOUT = 3;

  localparam int FIN_A   = 0;
  localparam int FIN_SDI = 6;

  localparam int FOUT_SCK = 0;
  localparam int FOUT_SDO = 1;
  localparam int FOUT_CS  = 2;

  localparam logic [SEL_W-1:0] CODE_OFF  = 8'h00;
  localparam logic [SEL_W-1:0] CODE_LOW  = 8'h01;
  localparam logic [SEL_W-1:0] CODE_HIGH = 8'h02;
  localparam logic [SEL_W-1:0] CODE_HIZ  = 8'h03;
  localparam logic [SEL_W-1:0] CODE_A    = 8'h04;
  localparam logic [SEL_W-1:0] CODE_SCK  = 8'h0A;
  localparam logic [SEL_W-1:0] CODE_SDI  = 8'h0B;
  localparam logic [SEL_W-1:0] CODE_SDO  = 8'h0C;
  localparam logic [SEL_W-1:0] CODE_CS   = 8'h0D;

  // selection code that feeds function input k
  function automatic logic [SEL_W-1:0] fin_code(input int k);
    if (k == FIN_SDI) return CODE_SDI;
    return CODE_A + SEL_W'(k);
  endfunction

endpackage

// File: rtl/pin_xbar_cfg.sv
module pin_xbar_cfg
  import pin_xbar_pkg::*;
#(
  parameter int NUM_PINS = 24
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic [$clog2(NUM_PINS)-1:0]       cfg_addr,
  input  logic                              cfg_we,
  input  logic [SEL_W-1:0]                  cfg_wdata,
  output logic [SEL_W-1:0]                  cfg_rdata,
  output logic [NUM_PINS-1:0][SEL_W-1:0]    sel_o
);

  localparam int AW = $clog2(NUM_PINS);
  localparam logic [AW-1:0] LAST_ADDR = AW'(NUM_PINS - 1);

  logic [NUM_PINS-1:0][SEL_W-1:0] sel_q;
  logic                           in_rng;

  assign in_rng = (cfg_addr <= LAST_ADDR);
  assign sel_o  = sel_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q     <= '0;
      cfg_rdata <= '0;
    end else begin
      if (cfg_we && in_rng) sel_q[cfg_addr] <= cfg_wdata;
      cfg_rdata <= in_rng ? sel_q[cfg_addr] : '0;
    end
  end

  // R2: a write to a valid address lands in the addressed byte
  a_r2_write_lands: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && in_rng) |=> sel_q[$past(cfg_addr)] == $past(cfg_wdata));

  // R9: reads outside the pin range return zero
  a_r9_oob_read_zero: assert property (@(posedge clk) disable iff (rst)
    !in_rng |=> cfg_rdata == '0);

  // R1: read-back is cleared by reset
  a_r1_rdata_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> cfg_rdata == '0);

endmodule

// File: rtl/pin_xbar_pin_dec.sv
module pin_xbar_pin_dec
  import pin_xbar_pkg::*;
(
  input  logic [SEL_W-1:0]    sel,
  input  logic [NUM_FOUT-1:0] func_out,
  input  logic                pin_in,
  output logic                pin_o,
  output logic                pin_oe,
  output logic [NUM_FIN-1:0]  in_hit
);

  // output side
  always_comb begin
    pin_o  = 1'b0;
    pin_oe = 1'b0;
    case (sel)
      CODE_LOW:  pin_oe = 1'b1;
      CODE_HIGH: begin pin_oe = 1'b1; pin_o = 1'b1; end
      CODE_SCK:  begin pin_oe = 1'b1; pin_o = func_out[FOUT_SCK]; end
      CODE_SDO:  begin pin_oe = 1'b1; pin_o = func_out[FOUT_SDO]; end
      CODE_CS:   begin pin_oe = 1'b1; pin_o = func_out[FOUT_CS];  end
      default:   ;
    endcase
  end

  // input side: one comparator per function input
  for (genvar k = 0; k < NUM_FIN; k++) begin : g_hit
    assign in_hit[k] = pin_in && (sel == fin_code(k));
  end

endmodule

// File: rtl/pin_xbar_in_merge.sv
module pin_xbar_in_merge
  import pin_xbar_pkg::*;
#(
  parameter int NUM_PINS = 24
) (
  input  logic [NUM_PINS-1:0][NUM_FIN-1:0] hits,
  output logic [NUM_FIN-1:0]               func_in
);

  always_comb begin
    func_in = '0;
    for (int p = 0; p < NUM_PINS; p++) func_in = func_in | hits[p];
  end

endmodule

// File: rtl/pin_xbar.sv
module pin_xbar
  import pin_xbar_pkg::*;
#(
  parameter int NUM_PINS = 24
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [$clog2(NUM_PINS)-1:0] cfg_addr,
  input  logic                        cfg_we,
  input  logic [SEL_W-1:0]            cfg_wdata,
  output logic [SEL_W-1:0]            cfg_rdata,
  input  logic [NUM_FOUT-1:0]         func_out,
  output logic [NUM_FIN-1:0]          func_in,
  input  logic [NUM_PINS-1:0]         pin_i,
  output logic [NUM_PINS-1:0]         pin_o,
  output logic [NUM_PINS-1:0]         pin_oe
);

  logic [NUM_PINS-1:0][SEL_W-1:0]   sel;
  logic [NUM_PINS-1:0][NUM_FIN-1:0] hits;

  pin_xbar_cfg #(.NUM_PINS(NUM_PINS)) i_cfg (
    .clk       (clk),
    .rst       (rst),
    .cfg_addr  (cfg_addr),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .sel_o     (sel)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    pin_xbar_pin_dec i_dec (
      .sel      (sel[p]),
      .func_out (func_out),
      .pin_in   (pin_i[p]),
      .pin_o    (pin_o[p]),
      .pin_oe   (pin_oe[p]),
      .in_hit   (hits[p])
    );

    // R4: disabled and unassigned codes float the pin
    a_r4_unused_hiz: assert property (@(posedge clk) disable iff (rst)
      (sel[p] == CODE_OFF || sel[p] > CODE_CS) |-> (!pin_oe[p] && !pin_o[p]));

    // R5: serial clock fans out to every pin that selects it
    a_r5_sck_fanout: assert property (@(posedge clk) disable iff (rst)
      (sel[p] == CODE_SCK) |-> (pin_oe[p] && pin_o[p] == func_out[FOUT_SCK]));

    // R6: input-selected pins never drive
    a_r6_input_no_drive: assert property (@(posedge clk) disable iff (rst)
      ((sel[p] >= CODE_A && sel[p] < CODE_SCK) || sel[p] == CODE_SDI) |-> !pin_oe[p]);

    for (genvar k = 0; k < NUM_FIN; k++) begin : g_src
      // R7: a high pin forces its selected function input high
      a_r7_or_source: assert property (@(posedge clk) disable iff (rst)
        (sel[p] == fin_code(k) && pin_i[p]) |-> func_in[k]);
    end
  end

  pin_xbar_in_merge #(.NUM_PINS(NUM_PINS)) i_merge (
    .hits    (hits),
    .func_in (func_in)
  );

  // R1: every pin floats right after reset
  a_r1_reset_hiz: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pin_oe == '0 && pin_o == '0));

endmodule

// File: tb/test_pin_xbar.sv
module test_pin_xbar;

  localparam int CLK_P = 10;
  localparam int NP    = 24;
  localparam int AW    = $clog2(NP);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] cfg_addr = '0;
  logic          cfg_we = 1'b0;
  logic [7:0]    cfg_wdata = '0;
  logic [7:0]    cfg_rdata;
  logic [2:0]    func_out = '0;
  logic [6:0]    func_in;
  logic [NP-1:0] pin_i = '0;
  logic [NP-1:0] pin_o;
  logic [NP-1:0] pin_oe;

  always #(CLK_P/2) clk = ~clk;

  pin_xbar #(.NUM_PINS(NP)) i_pin_xbar (
    .clk(clk), .rst(rst), .cfg_addr(cfg_addr), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .func_out(func_out),
    .func_in(func_in), .pin_i(pin_i), .pin_o(pin_o), .pin_oe(pin_oe)
  );

  // kind: 0 rdata, 1 pin_o bit, 2 pin_oe bit, 3 func_in bit
  typedef struct {
    int         due;
    int         kind;
    int         idx;
    logic [7:0] exp;
    string      req;
  } item_t;

  item_t sb[$];
  int    total = 0;
  int    bad   = 0;
  int    cyc   = 0;
  bit    done  = 0;

  function automatic void compare(string req, string what, int idx,
                                  logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s[%0d] actual=%h expected=%h", req, what, idx, act, exp);
    end
  endfunction

  // monitor: samples a quarter period after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_P/4);
      cyc++;
      while (sb.size() != 0 && sb[0].due <= cyc) begin
        item_t it;
        it = sb.pop_front();
        case (it.kind)
          0: compare(it.req, "rdata",  0,      cfg_rdata,              it.exp);
          1: compare(it.req, "pin_o",  it.idx, {7'b0, pin_o[it.idx]},  it.exp);
          2: compare(it.req, "pin_oe", it.idx, {7'b0, pin_oe[it.idx]}, it.exp);
          default: compare(it.req, "func_in", it.idx, {7'b0, func_in[it.idx]}, it.exp);
        endcase
      end
    end
  end

  task automatic step();
    @(negedge clk);
  endtask

  task automatic push(int kind, int idx, logic [7:0] exp, string req);
    item_t it;
    it.due = cyc + 1; it.kind = kind; it.idx = idx; it.exp = exp; it.req = req;
    sb.push_back(it);
  endtask

  task automatic exp_pin(int idx, bit oe, bit o, string req);
    push(2, idx, {7'b0, oe}, req);
    push(1, idx, {7'b0, o}, req);
  endtask

  task automatic exp_fin(int idx, bit v, string req);
    push(3, idx, {7'b0, v}, req);
  endtask

  task automatic wr(int a, logic [7:0] d);
    cfg_addr = AW'(a); cfg_we = 1'b1; cfg_wdata = d;
    step();
    cfg_we = 1'b0;
  endtask

  task automatic rd(int a, logic [7:0] e, string req);
    cfg_addr = AW'(a);
    push(0, 0, e, req);
    step();
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    step();
    rst = 1'b1;
    repeat (3) step();
    rst = 1'b0;
    pin_i = '1;
    // R1: all pins floating, read-back clear; R7: nothing selected reads 0
    for (int p = 0; p < NP; p++) exp_pin(p, 0, 0, "R1");
    push(0, 0, 8'h00, "R1");
    for (int k = 0; k < 7; k++) exp_fin(k, 0, "R7");
    step();
    pin_i = '0;

    // R3: static codes
    wr(0, 8'h01); wr(1, 8'h02); wr(2, 8'h03);
    exp_pin(0, 1, 0, "R3"); exp_pin(1, 1, 1, "R3"); exp_pin(2, 0, 0, "R3");
    step();

    // R2: read-back, and read during write returns the old byte
    rd(1, 8'h02, "R2"); rd(2, 8'h03, "R2"); rd(0, 8'h01, "R2");
    cfg_addr = AW'(3); cfg_we = 1'b1; cfg_wdata = 8'h55;
    push(0, 0, 8'h00, "R2");
    step();
    cfg_we = 1'b0;
    rd(3, 8'h55, "R2");
    wr(3, 8'h00);

    // R9: out-of-range addresses
    wr(24, 8'h02); wr(31, 8'h02);
    rd(24, 8'h00, "R9"); rd(31, 8'h00, "R9");
    exp_pin(23, 0, 0, "R9"); exp_pin(0, 1, 0, "R9"); exp_pin(1, 1, 1, "R9");
    step();

    // R8: write acts right after its edge
    cfg_addr = AW'(4); cfg_we = 1'b1; cfg_wdata = 8'h02;
    exp_pin(4, 1, 1, "R8");
    step();
    cfg_we = 1'b0;

    // R5: output fan-out
    wr(5, 8'h0A); wr(16, 8'h0A); wr(23, 8'h0A); wr(6, 8'h0C); wr(7, 8'h0D);
    func_out = 3'b001;
    exp_pin(5, 1, 1, "R5"); exp_pin(16, 1, 1, "R5"); exp_pin(23, 1, 1, "R5");
    exp_pin(6, 1, 0, "R5"); exp_pin(7, 1, 0, "R5");
    step();
    func_out = 3'b110;
    exp_pin(5, 1, 0, "R5"); exp_pin(16, 1, 0, "R5"); exp_pin(23, 1, 0, "R5");
    exp_pin(6, 1, 1, "R5"); exp_pin(7, 1, 1, "R5");
    step();
    // R8: combinational func_out to pin_o
    func_out = 3'b001;
    #1 compare("R8", "pin_o", 16, {7'b0, pin_o[16]}, 8'h01);
    step();

    // R6: input routing, one pin at a time
    wr(8, 8'h04); wr(9, 8'h05); wr(10, 8'h06); wr(11, 8'h07);
    wr(12, 8'h08); wr(13, 8'h09); wr(14, 8'h0B);
    for (int k = 0; k < 7; k++) begin
      pin_i = '0;
      pin_i[8 + k] = 1'b1;
      for (int j = 0; j < 7; j++) exp_fin(j, (j == k), "R6");
      exp_pin(8 + k, 0, 0, "R6");
      step();
    end
    // R8: combinational pin_i to func_in
    pin_i = '0;
    pin_i[12] = 1'b1;
    #1 compare("R8", "func_in", 4, {7'b0, func_in[4]}, 8'h01);
    pin_i = '0;
    step();

    // R7: OR of several pins on input B
    wr(17, 8'h06); wr(18, 8'h06);
    for (int m = 0; m < 4; m++) begin
      pin_i = '0;
      pin_i[17] = m[0];
      pin_i[18] = m[1];
      exp_fin(2, (m != 0), "R7");
      exp_pin(17, 0, 0, "R7");
      step();
    end

    // R4: disabled and unassigned codes add nothing
    pin_i = '0;
    func_out = 3'b111;
    wr(20, 8'h04);
    pin_i[20] = 1'b1;
    exp_fin(0, 1, "R4");
    step();
    wr(20, 8'h0E);
    exp_fin(0, 0, "R4"); exp_pin(20, 0, 0, "R4");
    step();
    wr(20, 8'hFF);
    exp_fin(0, 0, "R4"); exp_pin(20, 0, 0, "R4");
    step();
    wr(20, 8'h00);
    exp_fin(0, 0, "R4"); exp_pin(20, 0, 0, "R4");
    step();

    while (sb.size() != 0) step();
    step();
    report();
  end

endmodule